// File: doc/BRIEF.md
# Standby Event Status Register

This block is a small register bank that lives on a standby supply and keeps track of whether its own contents can still be trusted. When the standby supply drops out, a validity flag goes low. While that flag is low the block forces the regulated-supply enable bit in its configuration output to 1, so that the regulated supply and the host microcontroller stay powered until the host reprograms the configuration byte. A configuration write makes the contents valid again.

The same register captures wakeup and line events for the host. Four general line-event strobes and one line-ADC drop-out event are sticky, and a read of the event register clears them. The drop-out event latches when the synchronized comparator output rises while the ADC control byte is non-zero. Each such latch also produces a one-cycle flag toward the main status register. The two ring-detect levels and the comparator level can be read live. An interrupt request is raised while any sticky event is set and its enable flag is on.

Top module: `stby_evt_reg`

## Requirements
- R1: A high `supply_drop_i` in a cycle clears the validity flag (event word bit 5) at that clock edge. If a configuration write falls in the same cycle, the drop wins: the written byte is discarded and the flag stays 0.
- R2: While the validity flag is 0, `cfg_o` bit 4 reads 1 whatever byte is stored. While the flag is 1, `cfg_o` equals the stored byte.
- R3: A write (`reg_wr_i` with `reg_addr_i` = CFG_ADDR) stores `reg_wdata_i` as the configuration byte and sets event word bit 5 to 1 from the next cycle on.
- R4: Event word bit 6 and bit 7 show the synchronized levels of `ring_a_i` and `ring_b_i` at the time of the read. They are not latched.
- R5: Event word bit 8 latches to 1 on a rising edge of (synchronized `adc_cmp_i` AND `adc_ctl_i` non-zero). `stat_flag_o` is high for exactly one cycle, the first cycle in which that new latch is visible.
- R6: While `adc_ctl_i` is all zeros, no drop-out event latches and `stat_flag_o` stays 0.
- R7: Event word bit 9 shows the live synchronized level of `adc_cmp_i`.
- R8: A high bit of `line_evt_i[3:0]` in a cycle sets the matching event word bit 0..3. A read (`reg_rd_i` with `reg_addr_i` = EVT_ADDR) clears bits 0..3 and bit 8 at the clock edge that ends the read cycle. The read returns the value from before the clear.
- R9: An event that sets a sticky bit in the same cycle as a clearing read leaves that bit at 1 after the read.
- R10: After reset the validity flag, all sticky bits, `stat_flag_o` and `irq_o` are 0. Event word bits 4 and 10..15 always read 0. `rd_data_o` is 0 in any cycle that is not an event register read.
- R11: `irq_o` is high exactly while some sticky bit is set with its enable on. `evt_en_i[3:0]` gates bits 0..3 and `evt_en_i[4]` gates bit 8.
- R12: A comparator held high after its event was read does not latch bit 8 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| supply_drop_i | input | 1 | Standby supply drop-out indication, synchronous |
| ring_a_i | input | 1 | First ring-detect pin level, asynchronous |
| ring_b_i | input | 1 | Second ring-detect pin level, asynchronous |
| adc_cmp_i | input | 1 | Line ADC comparator, 1 = line voltage below reference, asynchronous |
| adc_ctl_i | input | CTL_W | ADC reference control byte; all zeros disables drop-out events |
| line_evt_i | input | 4 | Line/wakeup event strobes for sticky bits 0..3 |
| evt_en_i | input | 5 | Interrupt enables: [3:0] for bits 0..3, [4] for bit 8 |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | CFG_W | Write data |
| rd_data_o | output | 16 | Event word during an event register read, else 0 |
| cfg_o | output | CFG_W | Configuration byte with bit 4 forced high while not valid |
| stat_flag_o | output | 1 | One-cycle pulse to main status bit 14 on a drop-out latch |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a comparator rising edge that lands on the same clock edge as a clearing read. Several registers lie between the pin and that edge. The stimulus first parks the comparator low long enough for the edge detector to settle. It then raises the pin and counts two clock edges, so that the edge pulse is live in the cycle where the read strobe is held. The bench then expects the read to return bit 8 low and the following read to return it high. A drop-out that coincides with a configuration write is driven the same way, in a single shared cycle.

// File: rtl/stby_evt_pkg.sv
package stby_evt_pkg;

  localparam int WORD_W   = 16;
  localparam int N_LINE   = 4;
  localparam int N_STICKY = N_LINE + 1;

  // Bit positions in the event word (read by host software)
  localparam int B_VALID  = 5;
  localparam int B_RING_A = 6;
  localparam int B_RING_B = 7;
  localparam int B_DROP   = 8;
  localparam int B_CMP    = 9;

  // Assemble the readable event word from sticky and live state
  function automatic logic [WORD_W-1:0] pack_word(
    input logic [N_STICKY-1:0] sticky,
    input logic                valid,
    input logic [1:0]          ring,
    input logic                cmp
  );
    logic [WORD_W-1:0] w;
    w                 = '0;
    w[N_LINE-1:0]     = sticky[N_LINE-1:0];
    w[B_VALID]        = valid;
    w[B_RING_A]       = ring[0];
    w[B_RING_B]       = ring[1];
    w[B_DROP]         = sticky[N_LINE];
    w[B_CMP]          = cmp;
    return w;
  endfunction

  // Interrupt: any sticky event with its enable on
  function automatic logic irq_of(
    input logic [N_STICKY-1:0] sticky,
    input logic [N_STICKY-1:0] en
  );
    return |(sticky & en);
  endfunction

endpackage

// File: rtl/stby_sync.sv
module stby_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[CHAIN_W-W-1:0], d};
  end

  assign q = chain[CHAIN_W-1 -: W];

endmodule

// File: rtl/stby_rise.sv
module stby_rise #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  for (genvar i = 0; i < W; i++) begin : g_rise
    assign rise[i] = lvl[i] & ~prev_q[i];
  end

endmodule

// File: rtl/stby_sticky.sv
module stby_sticky #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] q
);

  // Set has priority over clear so a coincident event is kept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= set | (q & ~{N{clr}});
  end

endmodule

// File: rtl/stby_cfg.sv
module stby_cfg #(
  parameter int CFG_W   = 8,
  parameter int PWR_BIT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drop,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  output logic             valid,
  output logic [CFG_W-1:0] cfg
);

  logic [CFG_W-1:0] cfg_q;
  logic             valid_q;
  logic             take_wr;

  assign take_wr = wr & ~drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (take_wr) cfg_q <= wdata;
      if (drop)         valid_q <= 1'b0;
      else if (take_wr) valid_q <= 1'b1;
    end
  end

  always_comb begin
    cfg          = cfg_q;
    cfg[PWR_BIT] = cfg_q[PWR_BIT] | ~valid_q;
  end

  assign valid = valid_q;

endmodule

// File: rtl/stby_evt_reg.sv
module stby_evt_reg
  import stby_evt_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter logic [7:0]  CFG_ADDR    = 8'h10,
  parameter logic [7:0]  EVT_ADDR    = 8'h11,
  parameter int          CFG_W       = 8,
  parameter int          CTL_W       = 8,
  parameter int          PWR_BIT     = 4,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_drop_i,
  input  logic              ring_a_i,
  input  logic              ring_b_i,
  input  logic              adc_cmp_i,
  input  logic [CTL_W-1:0]  adc_ctl_i,
  input  logic [N_LINE-1:0] line_evt_i,
  input  logic [N_STICKY-1:0] evt_en_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [CFG_W-1:0]  reg_wdata_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              stat_flag_o,
  output logic              irq_o
);

  localparam int SYNC_W = 3;

  // Named internal events (also observed by the checker)
  logic                cfg_wr;
  logic                evt_rd;
  logic                valid;
  logic [1:0]          s_ring;
  logic                s_cmp;
  logic                adc_qual;
  logic                adc_set;
  logic [N_STICKY-1:0] sticky_set;
  logic [N_STICKY-1:0] sticky;
  logic                stat_q;

  assign cfg_wr = reg_wr_i & (reg_addr_i == CFG_ADDR[ADDR_W-1:0]);
  assign evt_rd = reg_rd_i & (reg_addr_i == EVT_ADDR[ADDR_W-1:0]);

  stby_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({adc_cmp_i, ring_b_i, ring_a_i}),
    .q     ({s_cmp, s_ring})
  );

  assign adc_qual = s_cmp & (|adc_ctl_i);

  stby_rise #(.W(1)) u_rise (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl   (adc_qual),
    .rise  (adc_set)
  );

  assign sticky_set = {adc_set, line_evt_i};

  stby_sticky #(.N(N_STICKY)) u_sticky (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (sticky_set),
    .clr   (evt_rd),
    .q     (sticky)
  );

  stby_cfg #(.CFG_W(CFG_W), .PWR_BIT(PWR_BIT)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .drop  (supply_drop_i),
    .wr    (cfg_wr),
    .wdata (reg_wdata_i),
    .valid (valid),
    .cfg   (cfg_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= adc_set;
  end

  assign stat_flag_o = stat_q;
  assign rd_data_o   = evt_rd ? pack_word(sticky, valid, s_ring, s_cmp) : '0;
  assign irq_o       = irq_of(sticky, evt_en_i);

endmodule

// File: rtl/stby_evt_chk.sv
module stby_evt_chk #(
  parameter int CFG_W   = 8,
  parameter int CTL_W   = 8,
  parameter int PWR_BIT = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             supply_drop_i,
  input logic             cfg_wr,
  input logic             valid,
  input logic [CFG_W-1:0] cfg_o,
  input logic [CTL_W-1:0] adc_ctl_i,
  input logic             adc_set,
  input logic             evt_rd,
  input logic [4:0]       sticky,
  input logic             stat_flag_o,
  input logic             irq_o
);

  AST_DROP_INVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
    supply_drop_i |=> !valid); // R1

  AST_INVALID_POWERS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> cfg_o[PWR_BIT]); // R2

  AST_WRITE_REVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !supply_drop_i) |=> valid); // R3

  AST_ZERO_CTL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_ctl_i == '0) |-> !adc_set); // R6

  AST_STAT_WITH_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    stat_flag_o |-> sticky[4]); // R5

  AST_READ_CLEARS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd && !adc_set) |=> !sticky[4]); // R8

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    adc_set |=> sticky[4]); // R9

  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|sticky)); // R11

endmodule

bind stby_evt_reg stby_evt_chk #(
  .CFG_W   (CFG_W),
  .CTL_W   (CTL_W),
  .PWR_BIT (PWR_BIT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .supply_drop_i (supply_drop_i),
  .cfg_wr        (cfg_wr),
  .valid         (valid),
  .cfg_o         (cfg_o),
  .adc_ctl_i     (adc_ctl_i),
  .adc_set       (adc_set),
  .evt_rd        (evt_rd),
  .sticky        (sticky),
  .stat_flag_o   (stat_flag_o),
  .irq_o         (irq_o)
);

// File: tb/tb_stby_evt_reg.sv
`timescale 1ns/1ps
module tb_stby_evt_reg;

  localparam logic [7:0] CFG_A = 8'h10;
  localparam logic [7:0] EVT_A = 8'h11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        supply_drop_i = 1'b0;
  logic        ring_a_i = 1'b0;
  logic        ring_b_i = 1'b0;
  logic        adc_cmp_i = 1'b0;
  logic [7:0]  adc_ctl_i = 8'h00;
  logic [3:0]  line_evt_i = 4'h0;
  logic [4:0]  evt_en_i = 5'h00;
  logic [7:0]  reg_addr_i = 8'h00;
  logic        reg_wr_i = 1'b0;
  logic        reg_rd_i = 1'b0;
  logic [7:0]  reg_wdata_i = 8'h00;
  logic [15:0] rd_data_o;
  logic [7:0]  cfg_o;
  logic        stat_flag_o;
  logic        irq_o;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t sb[$];

  always #2.5 clk = ~clk; // 200 MHz

  stby_evt_reg dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_drop_i (supply_drop_i),
    .ring_a_i      (ring_a_i),
    .ring_b_i      (ring_b_i),
    .adc_cmp_i     (adc_cmp_i),
    .adc_ctl_i     (adc_ctl_i),
    .line_evt_i    (line_evt_i),
    .evt_en_i      (evt_en_i),
    .reg_addr_i    (reg_addr_i),
    .reg_wr_i      (reg_wr_i),
    .reg_rd_i      (reg_rd_i),
    .reg_wdata_i   (reg_wdata_i),
    .rd_data_o     (rd_data_o),
    .cfg_o         (cfg_o),
    .stat_flag_o   (stat_flag_o),
    .irq_o         (irq_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: queue the expected word, then hold the read strobe for one cycle
  task automatic rd_expect(input logic [15:0] exp, input string tag);
    sb.push_back('{exp: exp, tag: tag});
    reg_addr_i = EVT_A;
    reg_rd_i   = 1'b1;
    step();
    reg_rd_i   = 1'b0;
  endtask

  task automatic cfg_write(input logic [7:0] val);
    reg_addr_i  = CFG_A;
    reg_wdata_i = val;
    reg_wr_i    = 1'b1;
    step();
    reg_wr_i    = 1'b0;
  endtask

  // Monitor: compare the event word mid-cycle during every read
  always @(negedge clk) begin
    if (reg_rd_i && reg_addr_i == EVT_A) begin
      if (sb.size() == 0) begin
        nvec++;
        nbad++;
        $display("FAIL scoreboard empty actual=%h expected=none", rd_data_o);
      end else begin
        sb_item_t it;
        it = sb.pop_front();
        chk(it.tag, rd_data_o, it.exp);
      end
    end
  end

  initial begin
    steps(3);
    rst_n = 1'b1;
    step();

    // R10: reset state
    chk("R10 irq", {15'd0, irq_o}, 16'd0);
    chk("R10 stat", {15'd0, stat_flag_o}, 16'd0);
    chk("R10 idle rd_data", rd_data_o, 16'h0000);
    chk("R2 cfg forced while invalid", {8'd0, cfg_o}, 16'h0010);
    rd_expect(16'h0000, "R10 reset word");

    // R3: config write revalidates
    cfg_write(8'h25);
    chk("R3 cfg stored", {8'd0, cfg_o}, 16'h0025);
    rd_expect(16'h0020, "R3 valid bit");

    // R4: ring levels live, not latched
    ring_a_i = 1'b1;
    steps(3);
    rd_expect(16'h0060, "R4 ring a");
    rd_expect(16'h0060, "R4 ring a again");
    ring_a_i = 1'b0;
    ring_b_i = 1'b1;
    steps(3);
    rd_expect(16'h00A0, "R4 ring b");
    ring_b_i = 1'b0;
    steps(3);
    rd_expect(16'h0020, "R4 ring released");

    // R8 / R11: line events, interrupt, clear on read
    evt_en_i   = 5'b00001;
    line_evt_i = 4'b0101;
    step();
    line_evt_i = 4'h0;
    chk("R11 irq on enabled bit0", {15'd0, irq_o}, 16'd1);
    rd_expect(16'h0025, "R8 line events");
    chk("R11 irq after clear", {15'd0, irq_o}, 16'd0);
    rd_expect(16'h0020, "R8 cleared");
    line_evt_i = 4'b0100;
    step();
    line_evt_i = 4'h0;
    chk("R11 masked bit2", {15'd0, irq_o}, 16'd0);
    rd_expect(16'h0024, "R8 bit2");

    // R9: line event coincident with read
    line_evt_i = 4'b0010;
    rd_expect(16'h0020, "R9 pre-clear value");
    line_evt_i = 4'h0;
    rd_expect(16'h0022, "R9 event kept");

    // R5 / R7 / R12: drop-out event
    evt_en_i  = 5'b10000;
    adc_ctl_i = 8'h80;
    adc_cmp_i = 1'b1;
    steps(3);
    chk("R5 stat pulse", {15'd0, stat_flag_o}, 16'd1);
    chk("R11 irq on drop", {15'd0, irq_o}, 16'd1);
    step();
    chk("R5 stat one cycle", {15'd0, stat_flag_o}, 16'd0);
    rd_expect(16'h0320, "R5 drop latched");
    chk("R11 irq cleared", {15'd0, irq_o}, 16'd0);
    steps(3);
    rd_expect(16'h0220, "R12 no relatch");

    // R9: drop-out edge coincident with read
    adc_cmp_i = 1'b0;
    steps(3);
    adc_cmp_i = 1'b1;
    steps(2);
    rd_expect(16'h0220, "R9 adc pre-clear");
    rd_expect(16'h0320, "R9 adc kept");

    // R6 / R7: zero control byte suppresses
    adc_cmp_i = 1'b0;
    steps(3);
    adc_ctl_i = 8'h00;
    adc_cmp_i = 1'b1;
    steps(2);
    chk("R6 no stat", {15'd0, stat_flag_o}, 16'd0);
    steps(2);
    chk("R6 no stat later", {15'd0, stat_flag_o}, 16'd0);
    rd_expect(16'h0220, "R6 suppressed R7 live");
    adc_cmp_i = 1'b0;
    steps(3);
    rd_expect(16'h0020, "R7 comparator low");

    // R1 / R2: supply drop-out
    supply_drop_i = 1'b1;
    step();
    supply_drop_i = 1'b0;
    chk("R2 forced after drop", {8'd0, cfg_o}, 16'h0035);
    rd_expect(16'h0000, "R1 invalid");
    cfg_write(8'h10);
    rd_expect(16'h0020, "R3 revalid");
    cfg_write(8'h00);
    chk("R2 bit4 follows when valid", {8'd0, cfg_o}, 16'h0000);

    // R1: drop wins over coincident write
    supply_drop_i = 1'b1;
    cfg_write(8'h01);
    supply_drop_i = 1'b0;
    chk("R1 write discarded", {8'd0, cfg_o}, 16'h0010);
    rd_expect(16'h0000, "R1 drop beats write");

    step();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nvec++;
      nbad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

endmodule